// File: doc/BRIEF.md
# Coherent Byte-Access Register Bridge

This block sits between an 8-bit register bus and a 16-bit timer channel value register, which the bus sees as two byte addresses: a high byte and a low byte. Two 8-bit accesses to one 16-bit quantity could otherwise return bytes from two different samples, or expose a half-updated compare value to the timer. The bridge prevents both.

When the channel is in capture mode, the first byte read takes a copy of the whole live captured value. The bridge keeps that copy until the opposite byte has been read, so the two halves always come from one sample. When the channel is in compare or PWM mode, reads return the committed compare value directly. Byte writes are held in a staging buffer and move into the committed value together once both halves have arrived, in either order. A write to the channel status/control register drops any held snapshot and any staged byte.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset the committed compare value is zero, no snapshot is held and no byte is staged, so the first single-byte write does not commit and the first capture-mode read returns the live value.
- R2: With capture mode high and no snapshot held, a read of either byte returns that byte of the live captured value. The high byte is bits 15:8 when busSelHi is 1 and the low byte is bits 7:0 when it is 0. The same read copies all 16 live bits into a snapshot.
- R3: While a snapshot is held, capture-mode reads return bytes of the snapshot, and changes to the live value are not visible. Reading again the byte that took the snapshot keeps it held.
- R4: A capture-mode read of the byte opposite to the one that took the snapshot returns the snapshot byte and releases the snapshot, so the next read sees the live value again. This works in both orders.
- R5: With capture mode low, a read returns the selected byte of the committed compare value and takes no snapshot.
- R6: With capture mode low, a write to one byte while the opposite byte is not staged leaves the committed value unchanged.
- R7: A compare-mode write to one byte while the opposite byte is staged updates all 16 committed bits in a single step at the next clock edge and clears the staging. This works in both byte orders.
- R8: A second write to the same byte before the opposite byte is written replaces the staged byte and does not commit.
- R9: A control-register write clears the snapshot and both staging flags. A write in the same cycle is discarded. A read in the same cycle returns data but takes no snapshot.
- R10: Byte writes while capture mode is high are ignored: they neither stage nor commit.
- R11: busRdData is zero in every cycle where busRd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busRd | input | 1 | Byte read strobe |
| busWr | input | 1 | Byte write strobe |
| busSelHi | input | 1 | 1 selects the high byte, 0 the low byte |
| busWrData | input | 8 | Write data byte |
| busRdData | output | 8 | Read data byte, valid while busRd is high |
| captureMode | input | 1 | 1 when the channel is in capture mode, 0 in compare/PWM mode |
| ctrlWr | input | 1 | Write strobe of the channel status/control register |
| liveValue | input | 16 | Live captured counter value |
| cmpValue | output | 16 | Committed compare value |

## Verification
The directed cases read the two bytes in both orders while the live value changes between the reads. Any leak of the live value into a held snapshot therefore shows up as a byte mismatch. Other directed cases write the two bytes in both orders and repeat one byte before the other is written. These separate a correct paired commit from a premature single-byte commit and from a stale staged byte. Control-register writes are placed between the two halves of a read and of a write, to show that the held state is really dropped. A long stretch of random reads, writes, mode changes and control writes, all with a fixed seed, is compared every cycle against a bench-side model. This exposes ordering bugs that the directed cases do not reach.

// File: rtl/wide_reg_pkg.sv
package wide_reg_pkg;

  // Which byte of the 16-bit word an access targets
  typedef enum logic {
    LANE_LO = 1'b0,
    LANE_HI = 1'b1
  } laneSel_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic rdUseSnap;  // reads in capture mode come from the snapshot
    logic takeSnap;   // copy the live value into the snapshot
    logic stageHi;    // load the write byte into the high staging lane
    logic stageLo;    // load the write byte into the low staging lane
    logic commit;     // move the assembled word into the committed value
  } regStrobe_t;

endpackage

// File: rtl/wide_reg_ctrl.sv
module wide_reg_ctrl
  import wide_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busRd,
  input  logic       busWr,
  input  logic       busSelHi,
  input  logic       captureMode,
  input  logic       ctrlWr,
  output regStrobe_t strobe
);

  logic     rdLatched, latchNext;
  laneSel_e rdLatchLane, laneNext;
  logic     stagedHi, hiNext;
  logic     stagedLo, loNext;
  logic     rdAct, wrAct, otherStaged;
  laneSel_e accLane;

  always_comb begin
    accLane     = laneSel_e'(busSelHi);
    rdAct       = busRd && captureMode && !ctrlWr;
    wrAct       = busWr && !captureMode && !ctrlWr;
    otherStaged = (accLane == LANE_HI) ? stagedLo : stagedHi;

    strobe.rdUseSnap = rdLatched;
    strobe.takeSnap  = rdAct && !rdLatched;
    strobe.stageHi   = wrAct && (accLane == LANE_HI);
    strobe.stageLo   = wrAct && (accLane == LANE_LO);
    strobe.commit    = wrAct && otherStaged;
  end

  always_comb begin
    latchNext = rdLatched;
    laneNext  = rdLatchLane;
    hiNext    = stagedHi;
    loNext    = stagedLo;
    if (ctrlWr) begin
      latchNext = 1'b0;
      laneNext  = LANE_LO;
      hiNext    = 1'b0;
      loNext    = 1'b0;
    end else begin
      if (rdAct) begin
        if (!rdLatched) begin
          latchNext = 1'b1;
          laneNext  = accLane;
        end else if (accLane != rdLatchLane) begin
          latchNext = 1'b0;
        end
      end
      if (wrAct) begin
        if (otherStaged) begin
          hiNext = 1'b0;
          loNext = 1'b0;
        end else if (accLane == LANE_HI) begin
          hiNext = 1'b1;
        end else begin
          loNext = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdLatched   <= 1'b0;
      rdLatchLane <= LANE_LO;
      stagedHi    <= 1'b0;
      stagedLo    <= 1'b0;
    end else begin
      rdLatched   <= latchNext;
      rdLatchLane <= laneNext;
      stagedHi    <= hiNext;
      stagedLo    <= loNext;
    end
  end

  // R7
  staged_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stagedHi && stagedLo));

  // R9
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (!rdLatched && !stagedHi && !stagedLo));

  // R3
  same_lane_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdLatched && busRd && captureMode && !ctrlWr && (laneSel_e'(busSelHi) == rdLatchLane))
      |=> rdLatched);

endmodule

// File: rtl/wide_reg_dpath.sv
module wide_reg_dpath
  import wide_reg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strobe,
  input  logic                  busRd,
  input  logic                  busSelHi,
  input  logic [BYTE_W-1:0]     busWrData,
  input  logic                  captureMode,
  input  logic [2*BYTE_W-1:0]   liveValue,
  output logic [BYTE_W-1:0]     busRdData,
  output logic [2*BYTE_W-1:0]   cmpValue
);

  localparam int LANES  = 2;
  localparam int WORD_W = LANES * BYTE_W;

  logic [WORD_W-1:0] snapWord;
  logic [WORD_W-1:0] cmpWord;
  logic [WORD_W-1:0] commitWord;
  logic [WORD_W-1:0] rdWord;

  // Staging lanes: one byte register per lane, bypassed by the byte being written
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [BYTE_W-1:0] stageByte;
    logic              laneLoad;

    assign laneLoad = (lane == LANES - 1) ? strobe.stageHi : strobe.stageLo;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageByte <= '0;
      end else if (laneLoad) begin
        stageByte <= busWrData;
      end
    end

    assign commitWord[lane*BYTE_W +: BYTE_W] = laneLoad ? busWrData : stageByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapWord <= '0;
      cmpWord  <= '0;
    end else begin
      if (strobe.takeSnap) snapWord <= liveValue;
      if (strobe.commit)   cmpWord  <= commitWord;
    end
  end

  always_comb begin
    if (captureMode) begin
      rdWord = strobe.rdUseSnap ? snapWord : liveValue;
    end else begin
      rdWord = cmpWord;
    end
    if (!busRd) begin
      busRdData = '0;
    end else if (busSelHi) begin
      busRdData = rdWord[WORD_W-1 -: BYTE_W];
    end else begin
      busRdData = rdWord[BYTE_W-1:0];
    end
  end

  assign cmpValue = cmpWord;

  // R11
  idle_rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> (busRdData == '0));

  // R6
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(cmpValue));

endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wide_reg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busRd,
  input  logic                busWr,
  input  logic                busSelHi,
  input  logic [BYTE_W-1:0]   busWrData,
  output logic [BYTE_W-1:0]   busRdData,
  input  logic                captureMode,
  input  logic                ctrlWr,
  input  logic [2*BYTE_W-1:0] liveValue,
  output logic [2*BYTE_W-1:0] cmpValue
);

  localparam int WORD_W = 2 * BYTE_W;

  regStrobe_t strobe;

  wide_reg_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busRd       (busRd),
    .busWr       (busWr),
    .busSelHi    (busSelHi),
    .captureMode (captureMode),
    .ctrlWr      (ctrlWr),
    .strobe      (strobe)
  );

  wide_reg_dpath #(.BYTE_W(BYTE_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busRd       (busRd),
    .busSelHi    (busSelHi),
    .busWrData   (busWrData),
    .captureMode (captureMode),
    .liveValue   (liveValue),
    .busRdData   (busRdData),
    .cmpValue    (cmpValue)
  );

  // R10
  capture_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && captureMode) |=> $stable(cmpValue));

  // R5
  cmp_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !captureMode) |->
      (busRdData == (busSelHi ? cmpValue[WORD_W-1 -: BYTE_W] : cmpValue[BYTE_W-1:0])));

endmodule

// File: tb/wide_reg_bridge_bench.sv
`timescale 1ns/1ps
module wide_reg_bridge_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic        busSelHi = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        captureMode = 1'b0;
  logic        ctrlWr = 1'b0;
  logic [15:0] liveValue = '0;
  logic [15:0] cmpValue;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  // Bench-side model state
  bit          mLatched, mLatchHi, mStHi, mStLo;
  logic [15:0] mSnap, mCmp;
  logic [7:0]  mStHiB, mStLoB;

  always #10 clk = ~clk;

  wide_reg_bridge u_wide_reg_bridge (
    .clk, .rstN, .busRd, .busWr, .busSelHi, .busWrData, .busRdData,
    .captureMode, .ctrlWr, .liveValue, .cmpValue
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp,
                       input string tag, input string what);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input bit rd, input bit hi, input bit mode,
                                         input logic [15:0] live);
    logic [15:0] w;
    if (!rd) return 8'h00;
    w = mode ? (mLatched ? mSnap : live) : mCmp;
    return hi ? w[15:8] : w[7:0];
  endfunction

  task automatic modelStep(input bit rd, input bit wr, input bit hi, input logic [7:0] d,
                           input bit ctl, input bit mode, input logic [15:0] live);
    if (ctl) begin
      mLatched = 0; mStHi = 0; mStLo = 0;
    end else begin
      if (rd && mode) begin
        if (!mLatched) begin
          mSnap = live; mLatched = 1; mLatchHi = hi;
        end else if (hi != mLatchHi) begin
          mLatched = 0;
        end
      end
      if (wr && !mode) begin
        if (hi) begin
          if (mStLo) begin mCmp = {d, mStLoB}; mStHi = 0; mStLo = 0; end
          else begin mStHiB = d; mStHi = 1; end
        end else begin
          if (mStHi) begin mCmp = {mStHiB, d}; mStHi = 0; mStLo = 0; end
          else begin mStLoB = d; mStLo = 1; end
        end
      end
    end
  endtask

  task automatic doCycle(input bit rd, input bit wr, input bit hi, input logic [7:0] d,
                         input bit ctl, input bit mode, input logic [15:0] live,
                         input string tag);
    logic [7:0] e;
    @(negedge clk);
    busRd = rd; busWr = wr; busSelHi = hi; busWrData = d;
    ctrlWr = ctl; captureMode = mode; liveValue = live;
    #2;
    e = expRead(rd, hi, mode, live);
    check({8'h00, busRdData}, {8'h00, e}, tag, "read data");
    modelStep(rd, wr, hi, d, ctl, mode, live);
    @(posedge clk);
    #2;
    check(cmpValue, mCmp, tag, "compare value");
    busRd = 0; busWr = 0; ctrlWr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    mLatched = 0; mLatchHi = 0; mStHi = 0; mStLo = 0;
    mSnap = '0; mCmp = '0; mStHiB = '0; mStLoB = '0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R1: reset state and idle output (R11)
    check(cmpValue, 16'h0000, "R1", "reset compare value");
    doCycle(0, 0, 0, 8'h00, 0, 1, 16'hFFFF, "R11");
    doCycle(0, 1, 1, 8'hEE, 0, 0, 16'h0000, "R1");

    // R2, R3, R4: coherent snapshot, high byte first
    doCycle(0, 0, 0, 8'h00, 1, 1, 16'h0000, "R9");
    doCycle(1, 0, 1, 8'h00, 0, 1, 16'hA1B2, "R2");
    doCycle(1, 0, 1, 8'h00, 0, 1, 16'h1234, "R3");
    doCycle(1, 0, 0, 8'h00, 0, 1, 16'h5678, "R4");
    // low byte first
    doCycle(1, 0, 0, 8'h00, 0, 1, 16'h1234, "R2");
    doCycle(1, 0, 1, 8'h00, 0, 1, 16'h9ABC, "R4");
    doCycle(1, 0, 1, 8'h00, 0, 1, 16'hDEF0, "R4");
    doCycle(1, 0, 0, 8'h00, 0, 1, 16'h0F0F, "R4");

    // R5: compare-mode reads
    doCycle(1, 0, 1, 8'h00, 0, 0, 16'hFFFF, "R5");
    doCycle(1, 0, 0, 8'h00, 0, 0, 16'hFFFF, "R5");

    // R6, R8, R7: high first with overwrite
    doCycle(0, 1, 1, 8'h5A, 0, 0, 16'h0000, "R6");
    doCycle(0, 1, 1, 8'h6B, 0, 0, 16'h0000, "R8");
    doCycle(0, 1, 0, 8'h3C, 0, 0, 16'h0000, "R7");
    // low first
    doCycle(0, 1, 0, 8'h11, 0, 0, 16'h0000, "R6");
    doCycle(0, 1, 1, 8'h22, 0, 0, 16'h0000, "R7");
    doCycle(1, 0, 1, 8'h00, 0, 0, 16'h0000, "R5");

    // R9: control write between write halves
    doCycle(0, 1, 1, 8'h77, 0, 0, 16'h0000, "R9");
    doCycle(0, 0, 0, 8'h00, 1, 0, 16'h0000, "R9");
    doCycle(0, 1, 0, 8'h88, 0, 0, 16'h0000, "R9");
    doCycle(0, 1, 1, 8'h99, 0, 0, 16'h0000, "R9");
    // simultaneous write and control write is discarded
    doCycle(0, 1, 1, 8'h44, 0, 0, 16'h0000, "R9");
    doCycle(0, 1, 0, 8'h55, 1, 0, 16'h0000, "R9");
    doCycle(0, 1, 0, 8'h66, 0, 0, 16'h0000, "R9");
    // control write between read halves, and read with control write
    doCycle(1, 0, 1, 8'h00, 0, 1, 16'hCAFE, "R9");
    doCycle(0, 0, 0, 8'h00, 1, 1, 16'h0000, "R9");
    doCycle(1, 0, 0, 8'h00, 0, 1, 16'hBEEF, "R9");
    doCycle(1, 0, 1, 8'h00, 1, 1, 16'h1357, "R9");
    doCycle(1, 0, 1, 8'h00, 0, 1, 16'h2468, "R9");
    doCycle(0, 0, 0, 8'h00, 1, 1, 16'h0000, "R9");

    // R10: capture-mode writes ignored
    doCycle(0, 1, 1, 8'hAA, 0, 1, 16'h0000, "R10");
    doCycle(0, 1, 0, 8'hBB, 0, 1, 16'h0000, "R10");
    doCycle(0, 1, 0, 8'hCC, 0, 0, 16'h0000, "R10");
    doCycle(0, 0, 0, 8'h00, 1, 0, 16'h0000, "R10");

    // Random mix against the model
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      int unsigned op;
      bit rd, wr, ctl, mode;
      op   = $urandom_range(0, 9);
      rd   = (op < 4);
      wr   = (op >= 4 && op < 8);
      ctl  = (op == 8) || ($urandom_range(0, 31) == 0);
      mode = ($urandom_range(0, 3) != 0) ? (i % 400 < 200) : $urandom_range(0, 1);
      doCycle(rd, wr, $urandom_range(0, 1), 8'($urandom), ctl, mode,
              16'($urandom), "random");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule